// File: doc/BRIEF.md
# Memory-to-Memory Add Sequencer

This block is a hard-wired control sequencer that computes W = X + Y where X, Y and W are addresses in an external word memory. A one-cycle start pulse, sampled while the block is idle, captures three addresses. The block then runs a fixed list of ten register transfers and memory commands, one per step. It has a memory address register, a memory data register, three working registers (first operand, second operand, result) and an adder. Both operands are fetched, added, and the sum is written back to W.

Each memory step drives a read or write request and holds it until the memory returns a one-cycle completion pulse. Every other step takes exactly one cycle. The current step number is exported on its own port, so the system around the block can follow the sequence.

States, in order, with their step numbers: IDLE (0), LOAD_ADDR_X (1), READ_X (2), TAKE_A (3), LOAD_ADDR_Y (4), READ_Y (5), TAKE_B (6), SUM (7), PUT_SUM (8), LOAD_ADDR_W (9), WRITE_W (10). The transitions are:
- IDLE goes to LOAD_ADDR_X on start.
- READ_X, READ_Y and WRITE_W each stay put until the memory reports completion.
- WRITE_W returns to IDLE on completion.
- Every other state moves to the next state in the list after one cycle.

Top module: `mmadd_seq`

## Requirements
- R1: After reset, `step` is 0 and `busy`, `done`, `mem_rd` and `mem_wr` are all 0.
- R2: A start pulse in IDLE captures `x_addr`, `y_addr` and `w_addr`. After it, `step` takes the values 1 to 10 in ascending order, each exactly once, and then returns to 0.
- R3: `mem_rd` is high only in steps 2 and 5, and `mem_wr` only in step 10. The two are never high together, and `mem_addr` stays stable while a request is waiting.
- R4: In steps 2, 5 and 10 the block waits for `mem_done`. A step whose memory answers after L idle cycles lasts L+2 cycles.
- R5: The word written to address W equals the sum of the words read from X and Y, modulo 2^DATA_W. For example, 0xF0 + 0x25 stores 0x15.
- R6: `done` is high for exactly one cycle: the cycle right after the write completes. In that cycle `step` is 0.
- R7: A start pulse while the block is busy is ignored. The running operation keeps its captured addresses, and no second run follows.
- R8: With W equal to X, X is read first and then overwritten with the sum.
- R9: Steps 1, 3, 4, 6, 7, 8 and 9 each last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, sampled only in IDLE |
| x_addr | input | ADDR_W | Address of first operand |
| y_addr | input | ADDR_W | Address of second operand |
| w_addr | input | ADDR_W | Address for result |
| busy | output | 1 | High whenever the block is not in IDLE |
| done | output | 1 | One-cycle pulse after the write completes |
| step | output | 4 | Current step number, 0 in IDLE |
| mem_addr | output | ADDR_W | Memory address register |
| mem_wdata | output | DATA_W | Memory data register |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_rdata | input | DATA_W | Read data, valid with mem_done |
| mem_done | input | 1 | One-cycle memory completion pulse |

## Verification
The bench uses the default widths: 8-bit data and 8-bit addresses, with a 256-word memory model. This lets operand pairs whose sum exceeds 255 show the wraparound directly. The memory latency is set per scenario to 0, 1, 2 or 3 cycles, which changes the length of the waiting steps while the one-cycle steps stay fixed. A W-equal-X case and a start pulse issued mid-run with different addresses cover the overwrite order and the start-ignore rule.

// File: rtl/mmadd_pkg.sv
package mmadd_pkg;

    // State encoding equals the exported step number; order is the behaviour.
    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_LD_X     = 4'd1,
        ST_RD_X     = 4'd2,
        ST_TAKE_A   = 4'd3,
        ST_LD_Y     = 4'd4,
        ST_RD_Y     = 4'd5,
        ST_TAKE_B   = 4'd6,
        ST_SUM      = 4'd7,
        ST_PUT_SUM  = 4'd8,
        ST_LD_W     = 4'd9,
        ST_WR_W     = 4'd10
    } seq_state_t;

    typedef struct packed {
        logic mar_from_x;
        logic mar_from_y;
        logic mar_from_w;
        logic mdr_from_mem;
        logic mdr_from_sum;
        logic opa_load;
        logic opb_load;
        logic sum_load;
    } seq_ctl_t;

endpackage

// File: rtl/mmadd_alu.sv
module mmadd_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] sum
);
    localparam int FULL_W = DATA_W + 1;

    logic [FULL_W-1:0] full;

    always_comb begin
        full = {1'b0, opa} + {1'b0, opb};
        sum  = full[DATA_W-1:0];   // carry dropped: modulo 2^DATA_W (R5)
    end
endmodule

// File: rtl/mmadd_ctrl.sv
module mmadd_ctrl
    import mmadd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mem_done,
    output seq_state_t  state_q,
    output seq_ctl_t    ctl,
    output logic        capture,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        busy,
    output logic        done
);
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == ST_WR_W) && mem_done;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_LD_X;
            ST_LD_X:    state_d = ST_RD_X;
            ST_RD_X:    if (mem_done) state_d = ST_TAKE_A;
            ST_TAKE_A:  state_d = ST_LD_Y;
            ST_LD_Y:    state_d = ST_RD_Y;
            ST_RD_Y:    if (mem_done) state_d = ST_TAKE_B;
            ST_TAKE_B:  state_d = ST_SUM;
            ST_SUM:     state_d = ST_PUT_SUM;
            ST_PUT_SUM: state_d = ST_LD_W;
            ST_LD_W:    state_d = ST_WR_W;
            ST_WR_W:    if (mem_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl     = '0;
        capture = 1'b0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        unique case (state_q)
            ST_IDLE:    capture = start;
            ST_LD_X:    ctl.mar_from_x = 1'b1;
            ST_RD_X:    begin mem_rd = 1'b1; ctl.mdr_from_mem = mem_done; end
            ST_TAKE_A:  ctl.opa_load = 1'b1;
            ST_LD_Y:    ctl.mar_from_y = 1'b1;
            ST_RD_Y:    begin mem_rd = 1'b1; ctl.mdr_from_mem = mem_done; end
            ST_TAKE_B:  ctl.opb_load = 1'b1;
            ST_SUM:     ctl.sum_load = 1'b1;
            ST_PUT_SUM: ctl.mdr_from_sum = 1'b1;
            ST_LD_W:    ctl.mar_from_w = 1'b1;
            ST_WR_W:    mem_wr = 1'b1;
            default:    ctl = '0;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_wait_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_done) |=> $stable(state_q));

    p_one_cycle_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rd && !mem_wr) |=> (state_q != $past(state_q)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_in_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_IDLE));

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_wr && start) |=> busy);
endmodule

// File: rtl/mmadd_regs.sv
module mmadd_regs
    import mmadd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] x_in,
    input  logic [ADDR_W-1:0] y_in,
    input  logic [ADDR_W-1:0] w_in,
    input  seq_ctl_t          ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] alu_sum,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mdr,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb
);
    logic [ADDR_W-1:0] x_q, y_q, w_q;
    logic [DATA_W-1:0] res_q;

    // Address capture only on an accepted start (R2, R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            w_q <= '0;
        end else if (capture) begin
            x_q <= x_in;
            y_q <= y_in;
            w_q <= w_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar <= '0;
        end else if (ctl.mar_from_x) begin
            mar <= x_q;
        end else if (ctl.mar_from_y) begin
            mar <= y_q;
        end else if (ctl.mar_from_w) begin
            mar <= w_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdr <= '0;
        end else if (ctl.mdr_from_mem) begin
            mdr <= mem_rdata;
        end else if (ctl.mdr_from_sum) begin
            mdr <= res_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa   <= '0;
            opb   <= '0;
            res_q <= '0;
        end else begin
            if (ctl.opa_load) opa   <= mdr;
            if (ctl.opb_load) opb   <= mdr;
            if (ctl.sum_load) res_q <= alu_sum;
        end
    end

    p_wrap_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sum_load |=> (res_q == DATA_W'($past(opa) + $past(opb))));

    p_mdr_gets_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mdr_from_sum |=> (mdr == $past(res_q)));
endmodule

// File: rtl/mmadd_seq.sv
module mmadd_seq
    import mmadd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [ADDR_W-1:0] w_addr,
    output logic              busy,
    output logic              done,
    output logic [3:0]        step,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_done
);
    seq_state_t        state_q;
    seq_ctl_t          ctl;
    logic              capture;
    logic [DATA_W-1:0] opa, opb, alu_sum;

    mmadd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mem_done (mem_done),
        .state_q  (state_q),
        .ctl      (ctl),
        .capture  (capture),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .busy     (busy),
        .done     (done)
    );

    mmadd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .x_in      (x_addr),
        .y_in      (y_addr),
        .w_in      (w_addr),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .alu_sum   (alu_sum),
        .mar       (mem_addr),
        .mdr       (mem_wdata),
        .opa       (opa),
        .opb       (opb)
    );

    mmadd_alu #(.DATA_W(DATA_W)) u_alu (
        .opa (opa),
        .opb (opb),
        .sum (alu_sum)
    );

    assign step = state_q;

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_done) |=> $stable(mem_addr));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));
endmodule

// File: tb/tb_mmadd_seq.sv
module tb_mmadd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 8;
    localparam int TRACE_N = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] x_addr = '0, y_addr = '0, w_addr = '0;
    logic          busy, done, mem_rd, mem_wr;
    logic [3:0]    step;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_done = 1'b0;

    int checks = 0;
    int fails = 0;
    int lat = 0;
    int mcnt = 0;
    int cyc = 0;

    logic [DW-1:0] mem [256];
    logic          ld_req = 1'b0;
    logic [AW-1:0] ld_a = '0;
    logic [DW-1:0] ld_d = '0;

    logic [3:0] tr_step [TRACE_N];
    logic       tr_done [TRACE_N];
    int         tr_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmadd_seq #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_addr(x_addr), .y_addr(y_addr), .w_addr(w_addr),
        .busy(busy), .done(done), .step(step),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    // Memory model: answers after lat idle cycles with a one-cycle done pulse
    always @(posedge clk) begin
        if (ld_req) mem[ld_a] <= ld_d;
        if (mem_done) begin
            mem_done <= 1'b0;
            mcnt <= 0;
        end else if (mem_rd || mem_wr) begin
            if (mcnt == lat) begin
                mem_done <= 1'b1;
                if (mem_rd) mem_rdata <= mem[mem_addr];
                if (mem_wr) mem[mem_addr] <= mem_wdata;
                mcnt <= 0;
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ld_a = a; ld_d = d; ld_req = 1'b1;
        @(negedge clk);
        ld_req = 1'b0;
    endtask

    // One operation; optionally pulses start with other addresses mid-run
    task automatic run_op(input logic [AW-1:0] xa, input logic [AW-1:0] ya,
                          input logic [AW-1:0] wa, input logic extra,
                          input logic [AW-1:0] alt);
        int seen;
        seen = -1;
        @(negedge clk);
        x_addr = xa; y_addr = ya; w_addr = wa; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tr_n = 0;
        for (int c = 0; c < TRACE_N; c++) begin
            tr_step[c] = step;
            tr_done[c] = done;
            tr_n = c + 1;
            if (done && seen < 0) seen = c;
            if (seen >= 0 && c >= seen + 4) break;
            if (extra && c == 2) begin
                start = 1'b1; x_addr = alt; y_addr = alt; w_addr = alt;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    // Step order (R2), step lengths (R4, R9), done timing (R6, R7)
    task automatic check_trace(input string tag);
        int idx, len, exp_len, ndone;
        idx = 0;
        for (int s = 1; s <= 10; s++) begin
            len = 0;
            while (idx < tr_n && tr_step[idx] == 4'(s)) begin
                len++; idx++;
            end
            exp_len = (s == 2 || s == 5 || s == 10) ? lat + 2 : 1;
            if (s == 2 || s == 5 || s == 10)
                chk(len == exp_len, {"R4 step length ", tag}, len, exp_len);
            else
                chk(len == exp_len, {"R2/R9 step presence/length ", tag}, len, exp_len);
        end
        chk(idx < tr_n && tr_step[idx] == 4'd0, {"R2 return to idle ", tag},
            idx < tr_n ? int'(tr_step[idx]) : -1, 0);
        chk(idx < tr_n && tr_done[idx] == 1'b1, {"R6 done right after write ", tag},
            idx < tr_n ? int'(tr_done[idx]) : -1, 1);
        ndone = 0;
        for (int c = 0; c < tr_n; c++) if (tr_done[c]) ndone++;
        chk(ndone == 1, {"R6 single done pulse ", tag}, ndone, 1);
        for (int c = idx; c < tr_n; c++)
            if (tr_step[c] != 4'd0)
                chk(1'b0, {"R7 no second run ", tag}, int'(tr_step[c]), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(step == 4'd0, "R1 step", step, 0);
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(!mem_rd && !mem_wr, "R1 mem requests", {mem_rd, mem_wr}, 0);
    endtask

    task automatic t_basic();
        lat = 0;
        poke(8'h10, 8'h12);
        poke(8'h20, 8'h34);
        poke(8'h30, 8'h00);
        run_op(8'h10, 8'h20, 8'h30, 1'b0, 8'h00);
        check_trace("basic");
        chk(mem[8'h30] == 8'h46, "R5 basic sum", mem[8'h30], 8'h46);
        chk(mem[8'h10] == 8'h12 && mem[8'h20] == 8'h34, "R5 operands kept",
            {mem[8'h10], mem[8'h20]}, 16'h1234);
    endtask

    task automatic t_wrap();
        lat = 3;
        poke(8'h01, 8'hF0);
        poke(8'hFE, 8'h25);
        run_op(8'h01, 8'hFE, 8'h80, 1'b0, 8'h00);
        check_trace("wrap");
        chk(mem[8'h80] == 8'h15, "R5 wrap sum", mem[8'h80], 8'h15);
    endtask

    task automatic t_w_is_x();
        lat = 1;
        poke(8'h44, 8'h07);
        poke(8'h45, 8'h09);
        run_op(8'h44, 8'h45, 8'h44, 1'b0, 8'h00);
        check_trace("w_eq_x");
        chk(mem[8'h44] == 8'h10, "R8 overwrite X", mem[8'h44], 8'h10);
        chk(mem[8'h45] == 8'h09, "R8 Y untouched", mem[8'h45], 8'h09);
    endtask

    task automatic t_busy_start();
        lat = 2;
        poke(8'h50, 8'h21);
        poke(8'h51, 8'h22);
        poke(8'h52, 8'h00);
        poke(8'h99, 8'hAA);
        run_op(8'h50, 8'h51, 8'h52, 1'b1, 8'h99);
        check_trace("busy_start");
        chk(mem[8'h52] == 8'h43, "R7 captured addresses used", mem[8'h52], 8'h43);
        chk(mem[8'h99] == 8'hAA, "R7 alternate W untouched", mem[8'h99], 8'hAA);
        chk(!busy && step == 4'd0, "R7 idle after run", step, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wrap();
        t_w_is_x();
        t_busy_start();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule